// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Bank with Selectable Timebase

This block holds four countdown event timers (channels 0 to 3) and one free-running 32-bit up-counter that serves as a timestamp source. All five share one control word. For each channel, that word holds an enable bit, a reload-mode bit and a tick-rate select. A prescaler runs from the system clock and divides it down to pulses at 1 µs, 10 µs, 100 µs and 1 ms. The parameter `CYC_PER_US` gives the number of system clock cycles in one microsecond.

Software writes a start value into a channel register. That value becomes both the reload value and the live count. Software then sets the channel's enable bit. On each selected tick the channel counts down by one. On the tick that finds the count at zero, the channel raises a one-cycle pulse on its interrupt line. In periodic mode it then reloads its start value. In one-shot mode it stops at zero until software writes the register again. The up-counter takes its own tick select, which also offers the raw system clock. Reading its register returns the running count.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every register reads zero and all interrupt lines are low. Until the first clock edge, this includes the up-counter at byte offset 0x14.
- R2: The control word lives at byte offset 0x00. These bits are writable and read back: 19:16 (enables, channel 3 down to channel 0), 15:12 (modes, same order), 10:8 (up-counter select) and 7:0 (channel selects, two bits per channel, channel 0 in 1:0). All other bits read as zero, so writing all ones reads back as 0x000FF7FF.
- R3: A write to byte offset 0x04 + 4·i loads channel i with bits 15:0 of the write data, as both its reload value and its current count. A read of that offset returns the current count in bits 15:0, with zeros above.
- R4: A channel's 2-bit tick select picks the rate at which it counts down: 0 gives one tick per microsecond, 1 per 10 µs, 2 per 100 µs and 3 per 1 ms. One microsecond lasts `CYC_PER_US` clock cycles.
- R5: A channel counts only while its enable bit (bit 16 + i) is set. Once the bit is clear, the count holds its value.
- R6: With mode bit 12 + i set (periodic), a channel loaded with N raises its interrupt once every N+1 ticks and reloads N each time it does.
- R7: With the mode bit clear (one-shot), a channel raises exactly one interrupt and then stays at zero. Its enable bit stays set. A new write to the channel register arms it again.
- R8: Interrupt line `irq[i]` is a pulse that lasts one clock cycle. It is raised only on the tick that finds channel i enabled with a count of zero.
- R9: The up-counter's select is control bits 10:8. Select 0 counts every system clock cycle, 1 counts every 1 µs, 2 every 10 µs, 3 every 100 µs and 4 every 1 ms. It adds one per tick and wraps at 32 bits.
- R10: Selects 5 to 7 hold the up-counter. Writes to offset 0x14 have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte address; only word-aligned accesses take effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 4 | Interrupt pulse for each channel |

## Verification
The hardest case to reach is the 1 ms timebase, which needs three cascaded decade stages of the prescaler to line up. The bench sets `CYC_PER_US` to 2 so that a 1 ms tick lasts 2000 cycles. It then sweeps every channel through every tick select, with a different load per channel, and measures the steady spacing of the interrupts against (N+1)·CYC_PER_US·10^sel. The bench works out rates by taking the difference between two register reads spaced a whole number of tick periods apart, so the prescaler's phase has no effect on any expected value.

// File: rtl/ttb_pkg.sv
package ttb_pkg;

    localparam int NCH = 4;
    localparam int EW  = 32;

    // word index of each register (byte offset / 4)
    localparam logic [2:0] IDX_CTRL = 3'd0;
    localparam logic [2:0] IDX_UPC  = 3'd5;

    typedef struct packed {
        logic sys;
        logic us;
        logic us10;
        logic us100;
        logic ms;
    } tick_t;

    typedef struct packed {
        logic [NCH-1:0]      en;
        logic [NCH-1:0]      periodic;
        logic [2:0]          upc_sel;
        logic [NCH-1:0][1:0] ch_sel;
    } ctrl_t;

    typedef struct packed {
        ctrl_t         ctrl;
        logic [EW-1:0] upc;
    } bank_st_t;

    function automatic logic [31:0] pack_ctrl(ctrl_t c);
        return {12'd0, c.en, c.periodic, 1'b0, c.upc_sel, c.ch_sel};
    endfunction

endpackage

// File: rtl/ttb_prescaler.sv
module ttb_prescaler #(
    parameter int CYC_PER_US = 50
) (
    input  logic           clk,
    input  logic           rst_n,
    output ttb_pkg::tick_t ticks
);
    localparam int UW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [UW-1:0] U_LAST = UW'(CYC_PER_US - 1);

    typedef struct packed {
        logic [UW-1:0] ucnt;
        logic [3:0]    dec1;
        logic [3:0]    dec2;
        logic [3:0]    dec3;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic p_us, p_10, p_100, p_ms;

    always_comb begin
        p_us  = (st_q.ucnt == U_LAST);
        p_10  = p_us  && (st_q.dec1 == 4'd9);
        p_100 = p_10  && (st_q.dec2 == 4'd9);
        p_ms  = p_100 && (st_q.dec3 == 4'd9);

        st_d = st_q;
        st_d.ucnt = p_us ? '0 : st_q.ucnt + 1'b1;
        if (p_us)  st_d.dec1 = (st_q.dec1 == 4'd9) ? 4'd0 : st_q.dec1 + 4'd1;
        if (p_10)  st_d.dec2 = (st_q.dec2 == 4'd9) ? 4'd0 : st_q.dec2 + 4'd1;
        if (p_100) st_d.dec3 = (st_q.dec3 == 4'd9) ? 4'd0 : st_q.dec3 + 4'd1;

        ticks.sys   = 1'b1;
        ticks.us    = p_us;
        ticks.us10  = p_10;
        ticks.us100 = p_100;
        ticks.ms    = p_ms;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ttb_chan.sv
module ttb_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          en,
    input  logic          periodic,
    input  logic          tick,
    output logic [CW-1:0] count,
    output logic          irq
);
    typedef struct packed {
        logic [CW-1:0] reload;
        logic [CW-1:0] cnt;
        logic          done;
        logic          irq;
    } ch_st_t;

    ch_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (load) begin
            st_d.reload = load_val;
            st_d.cnt    = load_val;
            st_d.done   = 1'b0;
        end else if (en && tick && !st_q.done) begin
            if (st_q.cnt == '0) begin
                st_d.irq = 1'b1;
                if (periodic) st_d.cnt  = st_q.reload;
                else          st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign irq   = st_q.irq;

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank #(
    parameter int CYC_PER_US = 50,
    parameter int CW         = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [3:0]  irq
);
    import ttb_pkg::*;

    localparam int CWR = (CW < 32) ? CW : 32;

    bank_st_t          st_d, st_q;
    tick_t             ticks;
    logic [2:0]        widx;
    logic              aligned;
    logic [NCH-1:0]    ch_load;
    logic [NCH-1:0]    ch_tick;
    logic [NCH-1:0][CW-1:0] ch_cnt;
    logic              upc_tick;

    ttb_prescaler #(.CYC_PER_US(CYC_PER_US)) i_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .ticks (ticks)
    );

    assign widx    = bus_addr[4:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_load[g] = bus_wr && aligned && (widx == 3'(g + 1));

        always_comb begin
            case (st_q.ctrl.ch_sel[g])
                2'd0:    ch_tick[g] = ticks.us;
                2'd1:    ch_tick[g] = ticks.us10;
                2'd2:    ch_tick[g] = ticks.us100;
                default: ch_tick[g] = ticks.ms;
            endcase
        end

        ttb_chan #(.CW(CW)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ch_load[g]),
            .load_val (bus_wdata[CW-1:0]),
            .en       (st_q.ctrl.en[g]),
            .periodic (st_q.ctrl.periodic[g]),
            .tick     (ch_tick[g]),
            .count    (ch_cnt[g]),
            .irq      (irq[g])
        );
    end

    always_comb begin
        case (st_q.ctrl.upc_sel)
            3'd0:    upc_tick = ticks.sys;
            3'd1:    upc_tick = ticks.us;
            3'd2:    upc_tick = ticks.us10;
            3'd3:    upc_tick = ticks.us100;
            3'd4:    upc_tick = ticks.ms;
            default: upc_tick = 1'b0;
        endcase

        st_d = st_q;
        if (upc_tick) st_d.upc = st_q.upc + 1'b1;
        if (bus_wr && aligned && widx == IDX_CTRL) begin
            st_d.ctrl.en       = bus_wdata[19:16];
            st_d.ctrl.periodic = bus_wdata[15:12];
            st_d.ctrl.upc_sel  = bus_wdata[10:8];
            st_d.ctrl.ch_sel   = bus_wdata[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (widx)
                IDX_CTRL: bus_rdata = pack_ctrl(st_q.ctrl);
                3'd1, 3'd2, 3'd3, 3'd4:
                          bus_rdata[CWR-1:0] = ch_cnt[widx - 3'd1][CWR-1:0];
                IDX_UPC:  bus_rdata = st_q.upc;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ttb_chk.sv
module ttb_chk #(
    parameter int CW = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [4:0]            bus_addr,
    input logic [3:0]            en,
    input logic [3:0]            periodic,
    input logic [2:0]            upc_sel,
    input logic [31:0]           upc,
    input logic [3:0][CW-1:0]    cnt,
    input logic [3:0]            irq
);
    for (genvar g = 0; g < 4; g++) begin : g_p
        // R5
        frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[g] && !(bus_wr && bus_addr == 5'(4 * (g + 1)))) |=> $stable(cnt[g]));
        // R8
        irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> ($past(cnt[g]) == '0 && $past(en[g])));
        // R7
        oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[g] && !$past(periodic[g])) |-> (cnt[g] == '0));
    end

    // R9
    upc_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_sel == 3'd0) |=> (upc == $past(upc) + 32'd1));

    // R10
    upc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_sel > 3'd4) |=> $stable(upc));

endmodule

bind tick_timer_bank ttb_chk #(.CW(CW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .en       (st_q.ctrl.en),
    .periodic (st_q.ctrl.periodic),
    .upc_sel  (st_q.ctrl.upc_sel),
    .upc      (st_q.upc),
    .cnt      (ch_cnt),
    .irq      (irq)
);

// File: tb/test_tick_timer_bank.sv
module test_tick_timer_bank;
    localparam int CYC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ncnt  [4];
    int tlast [4];
    int tprev [4];
    logic [3:0] irq_prev = '0;
    int dbl = 0;

    always #5 clk = ~clk;

    tick_timer_bank #(.CYC_PER_US(CYC), .CW(16)) i_tick_timer_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    initial begin
        for (int i = 0; i < 4; i++) begin
            ncnt[i] = 0; tlast[i] = 0; tprev[i] = 0;
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            for (int i = 0; i < 4; i++) begin
                if (irq[i]) begin
                    tprev[i] = tlast[i];
                    tlast[i] = cyc;
                    ncnt[i]  = ncnt[i] + 1;
                    if (irq_prev[i]) dbl = dbl + 1;
                end
            end
        end
        irq_prev = irq;
        if (cyc == 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_irqs(input int ch, input int n);
        int base;
        int t;
        base = ncnt[ch];
        t = 0;
        while (ncnt[ch] < base + n && t < 100000) begin
            @(negedge clk);
            t++;
        end
    endtask

    function automatic int tick_len(input int sel);
        int v;
        v = CYC;
        for (int k = 0; k < sel; k++) v = v * 10;
        return v;
    endfunction

    logic [31:0] v1, v2;

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state, read before the first edge after release
        rd(5'h14, v1); chk("R1 upcounter", v1, 32'h0);
        for (int a = 0; a < 5; a++) begin
            rd(5'(4 * a), v1); chk("R1 register", v1, 32'h0);
        end
        chk("R1 irq", 32'(irq), 32'h0);

        // R2: control readback mask
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, v1); chk("R2 control mask", v1, 32'h000F_F7FF);
        wr(5'h00, 32'h0000_0000);
        rd(5'h00, v1); chk("R2 control clear", v1, 32'h0);

        // R3 / R5: load and hold while disabled
        wr(5'h0C, 32'hABCD_03E8);
        idle(30);
        rd(5'h0C, v1); chk("R3 R5 load readback held", v1, 32'd1000);

        // R4: sel 0 rate, 10 ticks in 10*CYC cycles
        wr(5'h00, 32'h0004_0000);
        rd(5'h0C, v1); idle(10 * CYC); rd(5'h0C, v2);
        chk("R4 channel 1us rate", v1 - v2, 32'd10);

        // R5: clearing enable freezes count
        wr(5'h00, 32'h0);
        rd(5'h0C, v1); idle(50); rd(5'h0C, v2);
        chk("R5 frozen", v2, v1);

        // R6 / R4: periodic sweep, every channel, every select, load N = channel
        for (int ch = 0; ch < 4; ch++) begin
            for (int sel = 0; sel < 4; sel++) begin
                wr(5'h00, 32'h0);
                wr(5'(4 * (ch + 1)), 32'(ch));
                wr(5'h00, (32'h1 << (16 + ch)) | (32'h1 << (12 + ch)) | (32'(sel) << (2 * ch)));
                wait_irqs(ch, 3);
                chk($sformatf("R6 R4 period ch%0d sel%0d", ch, sel),
                    32'(tlast[ch] - tprev[ch]), 32'((ch + 1) * tick_len(sel)));
            end
        end
        wr(5'h00, 32'h0);

        // R7: one-shot on channel 1
        wr(5'h08, 32'd4);
        v1 = 32'(ncnt[1]);
        wr(5'h00, 32'h0002_0000);
        idle(5 * CYC + 40);
        chk("R7 single irq", 32'(ncnt[1]) - v1, 32'd1);
        rd(5'h08, v2); chk("R7 stays zero", v2, 32'd0);
        rd(5'h00, v2); chk("R7 enable kept", v2, 32'h0002_0000);
        wr(5'h08, 32'd3);
        idle(4 * CYC + 40);
        chk("R7 rearm", 32'(ncnt[1]) - v1, 32'd2);
        wr(5'h00, 32'h0);

        // R9: up-counter rates
        wr(5'h00, 32'h0000_0000);
        rd(5'h14, v1); idle(20); rd(5'h14, v2);
        chk("R9 sysclk rate", v2 - v1, 32'd20);
        wr(5'h00, 32'h0000_0100);
        rd(5'h14, v1); idle(20 * CYC); rd(5'h14, v2);
        chk("R9 1us rate", v2 - v1, 32'd20);
        wr(5'h00, 32'h0000_0200);
        rd(5'h14, v1); idle(5 * tick_len(1)); rd(5'h14, v2);
        chk("R9 10us rate", v2 - v1, 32'd5);
        wr(5'h00, 32'h0000_0300);
        rd(5'h14, v1); idle(3 * tick_len(2)); rd(5'h14, v2);
        chk("R9 100us rate", v2 - v1, 32'd3);
        wr(5'h00, 32'h0000_0400);
        rd(5'h14, v1); idle(2 * tick_len(3)); rd(5'h14, v2);
        chk("R9 1ms rate", v2 - v1, 32'd2);

        // R10: held selects and ignored writes
        for (int s = 5; s < 8; s++) begin
            wr(5'h00, 32'(s) << 8);
            rd(5'h14, v1); idle(30); rd(5'h14, v2);
            chk("R10 held", v2, v1);
        end
        wr(5'h14, 32'h1234_5678);
        rd(5'h14, v2); chk("R10 write ignored", v2, v1);

        // R8: no interrupt pulse ever lasted two cycles
        chk("R8 single-cycle pulses", 32'(dbl), 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule